// File: doc/BRIEF.md
# Load/Store Address Generator

This block forms the memory address for a single-register load or store and the value the base register should take afterwards. It takes a base value, an index value, a 12-bit immediate and a set of mode controls, chooses the offset (immediate, plain index or shifted index), adds or subtracts it, and picks which of the two results goes to memory, according to the indexing mode.

It also tests the memory address against the access size. A misaligned access raises a fault flag, and the fault blocks the base update.

All results are registered on the clock edge where `valid_in` is high. They appear one cycle later together with `valid_out`. The block does no memory access and holds no register file.

Top module: `mem_addr_gen`

## Requirements
- R1: With `post_idx`=0 (pre-index), `mem_addr` and `new_base` both equal base ± offset. If no fault is raised, `base_we` equals `wb_req`.
- R2: With `post_idx`=1 (post-index), `mem_addr` equals the unmodified base and `new_base` equals base ± offset. If no fault is raised, `base_we` is 1 whatever the value of `wb_req`.
- R3: With `off_kind`=00, the offset is `imm12` zero-extended. It is added when `sub_off`=0 and subtracted when `sub_off`=1.
- R4: With `off_kind`=01 or 11, the offset is `index_val` unshifted, and `shift_kind` and `shift_amt` have no effect.
- R5: With `off_kind`=10, `index_val` is shifted before use. The `shift_kind` encodings are 00 logical left, 01 logical right, 10 arithmetic right and 11 rotate right, each by `shift_amt`. The base is never shifted.
- R6: With a shift amount of 0, logical right gives 0 and arithmetic right gives 32 copies of the index sign bit. Rotate right and logical left pass the index unchanged.
- R7: `align_fault` is tested on `mem_addr`. The `acc_size` encodings are 00 byte (never faults), 01 halfword (faults when bit 0 is 1), and 10 or 11 word (faults when bits [1:0] are nonzero).
- R8: Whenever `align_fault` is 1, `base_we` is 0.
- R9: Address arithmetic is 32-bit and wraps modulo 2^32.
- R10: Outputs update on the rising edge where `valid_in`=1, and `valid_out` is 1 in the following cycle. After an edge with `valid_in`=0, `valid_out`, `base_we` and `align_fault` are 0, and `mem_addr` and `new_base` keep their values.
- R11: While `rst` is high, all outputs are 0 after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_in | input | 1 | Operation strobe |
| base_val | input | 32 | Base register value |
| index_val | input | 32 | Index register value |
| imm12 | input | 12 | Unsigned immediate offset |
| sub_off | input | 1 | 1 subtracts the offset, 0 adds it |
| post_idx | input | 1 | 1 post-index, 0 pre-index |
| wb_req | input | 1 | Base update request for pre-index |
| off_kind | input | 2 | Offset source select |
| shift_kind | input | 2 | Index shift type |
| shift_amt | input | 5 | Index shift amount |
| acc_size | input | 2 | Access size |
| valid_out | output | 1 | Results valid |
| mem_addr | output | 32 | Address sent to memory |
| new_base | output | 32 | Updated base value |
| base_we | output | 1 | Base write enable |
| align_fault | output | 1 | Misaligned access flag |

## Verification
Directed vectors set pre-index against post-index with the update request both on and off. This shows which sum goes to memory and when the base is written.

Each offset source is tried with shift fields that would change the result if they were used. All four shift types are tried at nonzero and zero amounts, so that the special cases at amount 0 are told apart from a plain shift.

Alignment is tried at every size with odd, half-aligned and aligned addresses, including post-index, where the unmodified base is the address tested. Random vectors then mix all fields, including wrap-around sums.

// File: rtl/mag_pkg.sv
package mag_pkg;

    typedef enum logic [1:0] {
        OFF_IMM     = 2'b00,
        OFF_REG     = 2'b01,
        OFF_SCALED  = 2'b10,
        OFF_REG_ALT = 2'b11
    } off_kind_e;

    typedef enum logic [1:0] {
        SH_LSL = 2'b00,
        SH_LSR = 2'b01,
        SH_ASR = 2'b10,
        SH_ROR = 2'b11
    } shift_e;

    typedef enum logic [1:0] {
        SZ_BYTE     = 2'b00,
        SZ_HALF     = 2'b01,
        SZ_WORD     = 2'b10,
        SZ_WORD_ALT = 2'b11
    } size_e;

    // low address bits that must be zero for an access of the given size
    function automatic logic [1:0] align_mask(size_e sz);
        case (sz)
            SZ_BYTE: return 2'b00;
            SZ_HALF: return 2'b01;
            default: return 2'b11;
        endcase
    endfunction

endpackage

// File: rtl/mag_shifter.sv
module mag_shifter
    import mag_pkg::*;
#(
    parameter int W    = 32,
    parameter int SH_W = $clog2(W)
) (
    input  logic [W-1:0]    din,
    input  shift_e          kind,
    input  logic [SH_W-1:0] amt,
    output logic [W-1:0]    dout
);
    logic [2*W-1:0] wide;
    logic [SH_W:0]  eff;

    always_comb begin
        // right shifts by zero stand for a full-width shift
        eff = ((kind == SH_LSR || kind == SH_ASR) && amt == '0)
              ? (SH_W+1)'(W) : {1'b0, amt};
        wide = '0;
        case (kind)
            SH_LSL: wide = {{W{1'b0}}, din} << amt;
            SH_LSR: wide = {{W{1'b0}}, din} >> eff;
            SH_ASR: wide = {{W{din[W-1]}}, din} >> eff;
            default: wide = {din, din} >> amt;
        endcase
        dout = wide[W-1:0];
    end
endmodule

// File: rtl/mag_offset.sv
module mag_offset
    import mag_pkg::*;
#(
    parameter int W     = 32,
    parameter int IMM_W = 12,
    parameter int SH_W  = $clog2(W)
) (
    input  logic [W-1:0]     base,
    input  logic [W-1:0]     index,
    input  logic [IMM_W-1:0] imm,
    input  off_kind_e        kind,
    input  logic             sub,
    input  shift_e           sh_kind,
    input  logic [SH_W-1:0]  sh_amt,
    output logic [W-1:0]     sum
);
    logic [W-1:0] shifted;
    logic [W-1:0] operand;

    mag_shifter #(.W(W), .SH_W(SH_W)) u_shift (
        .din  (index),
        .kind (sh_kind),
        .amt  (sh_amt),
        .dout (shifted)
    );

    always_comb begin
        case (kind)
            OFF_IMM:    operand = {{(W-IMM_W){1'b0}}, imm};
            OFF_SCALED: operand = shifted;
            default:    operand = index;
        endcase
        sum = sub ? (base - operand) : (base + operand);
    end
endmodule

// File: rtl/mag_align.sv
module mag_align
    import mag_pkg::*;
(
    input  logic [1:0] addr_lo,
    input  size_e      size,
    output logic       fault
);
    assign fault = |(addr_lo & align_mask(size));
endmodule

// File: rtl/mem_addr_gen.sv
module mem_addr_gen
    import mag_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IMM_W  = 12,
    localparam int SH_W  = $clog2(ADDR_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_in,
    input  logic [ADDR_W-1:0] base_val,
    input  logic [ADDR_W-1:0] index_val,
    input  logic [IMM_W-1:0]  imm12,
    input  logic              sub_off,
    input  logic              post_idx,
    input  logic              wb_req,
    input  logic [1:0]        off_kind,
    input  logic [1:0]        shift_kind,
    input  logic [SH_W-1:0]   shift_amt,
    input  logic [1:0]        acc_size,
    output logic              valid_out,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [ADDR_W-1:0] new_base,
    output logic              base_we,
    output logic              align_fault
);
    logic [ADDR_W-1:0] sum;
    logic [ADDR_W-1:0] addr_nxt;
    logic              fault_nxt;
    logic              we_nxt;

    mag_offset #(.W(ADDR_W), .IMM_W(IMM_W), .SH_W(SH_W)) u_off (
        .base    (base_val),
        .index   (index_val),
        .imm     (imm12),
        .kind    (off_kind_e'(off_kind)),
        .sub     (sub_off),
        .sh_kind (shift_e'(shift_kind)),
        .sh_amt  (shift_amt),
        .sum     (sum)
    );

    assign addr_nxt = post_idx ? base_val : sum;

    mag_align u_align (
        .addr_lo (addr_nxt[1:0]),
        .size    (size_e'(acc_size)),
        .fault   (fault_nxt)
    );

    assign we_nxt = (post_idx | wb_req) & ~fault_nxt;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_out   <= 1'b0;
            mem_addr    <= '0;
            new_base    <= '0;
            base_we     <= 1'b0;
            align_fault <= 1'b0;
        end else begin
            valid_out   <= valid_in;
            base_we     <= valid_in & we_nxt;
            align_fault <= valid_in & fault_nxt;
            if (valid_in) begin
                mem_addr <= addr_nxt;
                new_base <= sum;
            end
        end
    end
endmodule

// File: rtl/mag_checker.sv
module mag_checker #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         valid_in,
    input logic         post_idx,
    input logic [1:0]   acc_size,
    input logic [W-1:0] base_val,
    input logic         valid_out,
    input logic [W-1:0] mem_addr,
    input logic [W-1:0] new_base,
    input logic         base_we,
    input logic         align_fault
);
    a_r1_pre_addr_is_sum: assert property (@(posedge clk) disable iff (rst)
        valid_in && !post_idx |=> mem_addr == new_base);

    a_r2_post_addr_is_base: assert property (@(posedge clk) disable iff (rst)
        valid_in && post_idx |=> mem_addr == $past(base_val));

    a_r2_post_byte_writes: assert property (@(posedge clk) disable iff (rst)
        valid_in && post_idx && acc_size == 2'b00 |=> base_we);

    a_r7_byte_no_fault: assert property (@(posedge clk) disable iff (rst)
        valid_in && acc_size == 2'b00 |=> !align_fault);

    a_r8_fault_blocks_we: assert property (@(posedge clk) disable iff (rst)
        align_fault |-> !base_we);

    a_r10_valid_follows: assert property (@(posedge clk) disable iff (rst)
        valid_in |=> valid_out);

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !valid_in |=> !valid_out && !base_we && !align_fault && $stable(mem_addr));

    a_r11_reset_clears: assert property (@(posedge clk)
        rst |=> !valid_out && !base_we && !align_fault && mem_addr == '0);
endmodule

bind mem_addr_gen mag_checker #(.W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .valid_in    (valid_in),
    .post_idx    (post_idx),
    .acc_size    (acc_size),
    .base_val    (base_val),
    .valid_out   (valid_out),
    .mem_addr    (mem_addr),
    .new_base    (new_base),
    .base_we     (base_we),
    .align_fault (align_fault)
);

// File: tb/mem_addr_gen_bench.sv
module mem_addr_gen_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        valid_in = 1'b0;
    logic [31:0] base_val = '0, index_val = '0;
    logic [11:0] imm12 = '0;
    logic        sub_off = 1'b0, post_idx = 1'b0, wb_req = 1'b0;
    logic [1:0]  off_kind = '0, shift_kind = '0, acc_size = '0;
    logic [4:0]  shift_amt = '0;
    logic        valid_out, base_we, align_fault;
    logic [31:0] mem_addr, new_base;

    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] last_addr = '0, last_base = '0;

    mem_addr_gen u_mem_addr_gen (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] ref_shift(logic [31:0] v, logic [1:0] k, logic [4:0] a);
        case (k)
            2'd0: return v << a;
            2'd1: return (a == 0) ? 32'd0 : v >> a;
            2'd2: return (a == 0) ? {32{v[31]}} : 32'($signed(v) >>> a);
            default: return (a == 0) ? v : ((v >> a) | (v << (6'd32 - {1'b0, a})));
        endcase
    endfunction

    function automatic logic [31:0] ref_sum();
        logic [31:0] off;
        if (off_kind == 2'd0)      off = {20'd0, imm12};
        else if (off_kind == 2'd2) off = ref_shift(index_val, shift_kind, shift_amt);
        else                       off = index_val;
        return sub_off ? base_val - off : base_val + off;
    endfunction

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic step(string tag);
        logic [31:0] s, a;
        logic f, we;
        s = ref_sum();
        a = post_idx ? base_val : s;
        case (acc_size)
            2'd0: f = 1'b0;
            2'd1: f = a[0];
            default: f = |a[1:0];
        endcase
        we = (post_idx | wb_req) & ~f;
        valid_in = 1'b1;
        @(posedge clk);
        @(negedge clk);
        valid_in = 1'b0;
        chk(tag, "valid_out", {31'd0, valid_out}, 32'd1);
        chk(tag, "mem_addr", mem_addr, a);
        chk(tag, "new_base", new_base, s);
        chk(f ? "R8" : tag, "base_we", {31'd0, base_we}, {31'd0, we});
        chk("R7", "align_fault", {31'd0, align_fault}, {31'd0, f});
        last_addr = a;
        last_base = s;
    endtask

    task automatic drive(logic [31:0] b, logic [31:0] x, logic [11:0] im, logic sb,
                         logic po, logic wb, logic [1:0] ok, logic [1:0] sk,
                         logic [4:0] sa, logic [1:0] sz);
        base_val = b; index_val = x; imm12 = im; sub_off = sb; post_idx = po;
        wb_req = wb; off_kind = ok; shift_kind = sk; shift_amt = sa; acc_size = sz;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11 reset state
        chk("R11", "valid_out", {31'd0, valid_out}, 32'd0);
        chk("R11", "mem_addr", mem_addr, 32'd0);
        chk("R11", "base_we", {31'd0, base_we}, 32'd0);
        rst = 1'b0;

        // R1 pre-index, with and without update
        drive(32'h1000, 32'h0, 12'd4, 0, 0, 0, 2'd0, 2'd0, 5'd0, 2'd2); step("R1");
        drive(32'h1000, 32'h0, 12'd4, 0, 0, 1, 2'd0, 2'd0, 5'd0, 2'd2); step("R1");
        // R2 post-index writes back without the request
        drive(32'h1000, 32'h0, 12'd8, 0, 1, 0, 2'd0, 2'd0, 5'd0, 2'd2); step("R2");
        // R3 subtract the largest immediate
        drive(32'h2000, 32'h0, 12'hFFF, 1, 0, 1, 2'd0, 2'd0, 5'd0, 2'd0); step("R3");
        // R4 register offset ignores shift fields (kinds 01 and 11)
        drive(32'h100, 32'h30, 12'h7, 0, 0, 1, 2'd1, 2'd2, 5'd7, 2'd2); step("R4");
        drive(32'h100, 32'h30, 12'h7, 1, 0, 1, 2'd3, 2'd3, 5'd9, 2'd2); step("R4");
        // R5 each shift type
        drive(32'h100, 32'h3, 12'h0, 0, 0, 1, 2'd2, 2'd0, 5'd2, 2'd2); step("R5");
        drive(32'h100, 32'hF00, 12'h0, 0, 0, 1, 2'd2, 2'd1, 5'd4, 2'd2); step("R5");
        drive(32'h100, 32'h8000_0100, 12'h0, 0, 0, 1, 2'd2, 2'd2, 5'd4, 2'd0); step("R5");
        drive(32'h0, 32'h0000_00AB, 12'h0, 0, 0, 1, 2'd2, 2'd3, 5'd8, 2'd0); step("R5");
        // R6 amount zero cases
        drive(32'h40, 32'hFFFF_FFF0, 12'h0, 0, 0, 1, 2'd2, 2'd1, 5'd0, 2'd2); step("R6");
        drive(32'h40, 32'h8000_0000, 12'h0, 1, 0, 1, 2'd2, 2'd2, 5'd0, 2'd2); step("R6");
        drive(32'h40, 32'h0000_0010, 12'h0, 0, 0, 1, 2'd2, 2'd3, 5'd0, 2'd2); step("R6");
        // R7 alignment per size
        drive(32'h101, 32'h0, 12'h0, 0, 0, 1, 2'd0, 2'd0, 5'd0, 2'd1); step("R7");
        drive(32'h102, 32'h0, 12'h0, 0, 0, 1, 2'd0, 2'd0, 5'd0, 2'd1); step("R7");
        drive(32'h102, 32'h0, 12'h0, 0, 0, 1, 2'd0, 2'd0, 5'd0, 2'd3); step("R7");
        drive(32'h103, 32'h0, 12'h0, 0, 0, 1, 2'd0, 2'd0, 5'd0, 2'd0); step("R7");
        // R8 post-index fault on base, aligned sum would not fault
        drive(32'h102, 32'h0, 12'h2, 0, 1, 1, 2'd0, 2'd0, 5'd0, 2'd2); step("R8");
        // R9 wrap both ways
        drive(32'hFFFF_FFFC, 32'h0, 12'd8, 0, 0, 1, 2'd0, 2'd0, 5'd0, 2'd2); step("R9");
        drive(32'h0, 32'h4, 12'd0, 1, 0, 1, 2'd1, 2'd0, 5'd0, 2'd2); step("R9");
        // R10 idle cycle holds addresses, clears flags
        drive(32'hDEAD_BEEF, 32'h1, 12'h3, 0, 1, 1, 2'd1, 2'd0, 5'd0, 2'd2);
        @(posedge clk);
        @(negedge clk);
        chk("R10", "valid_out", {31'd0, valid_out}, 32'd0);
        chk("R10", "base_we", {31'd0, base_we}, 32'd0);
        chk("R10", "align_fault", {31'd0, align_fault}, 32'd0);
        chk("R10", "mem_addr", mem_addr, last_addr);
        chk("R10", "new_base", new_base, last_base);

        for (int i = 0; i < 3000; i++) begin
            logic [31:0] b;
            b = ($urandom_range(0, 3) == 0) ? (32'hFFFF_FF00 | $urandom) : $urandom;
            drive(b, $urandom, 12'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                  2'($urandom), 2'($urandom), 5'($urandom), 2'($urandom));
            step(post_idx ? "R2" : "R1");
            if ($urandom_range(0, 7) == 0) begin
                @(posedge clk);
                @(negedge clk);
                chk("R10", "valid_out idle", {31'd0, valid_out}, 32'd0);
                chk("R10", "mem_addr hold", mem_addr, last_addr);
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule